// File: doc/BRIEF.md
# OSD Command Stream Parser

This block sits behind an I2C slave byte engine and turns the byte stream of a write transfer into single-byte writes to the register memory of a character on-screen display. The memory is addressed as 16 rows by 32 columns. Rows 0 to 14 hold a character-code plane and an attribute plane, and row 15 holds control registers. Every received byte is classed as a row address, a column address or a data byte. Each accepted data byte leaves the block as one strobe on a write port. The strobe carries the target row, the target column, the plane select, the font page bit and the data.

Address bytes carry their own tags, so three write styles can share one transfer. A row address can be followed by a column address and one data byte. A column address alone can be followed by one data byte on the same row. A column address with the streaming tag makes every later byte data, with the column advancing after each write. A read transfer returns one byte: the reset-flag control register. A system reset clears that register. The byte engine supplies START/STOP events and assembled bytes, and it takes `ack` and `tx_byte` back.

Top module: `osd_cmd_parser`

## Requirements
- R1: In the byte after a START, 0x7A opens a write transfer and 0x7B opens a read transfer, and both are acknowledged. Any other value is not acknowledged, and every byte after it is ignored and not acknowledged until the next START.
- R2: In a write transfer, a byte in address position with bit 7 = 1 is a row address. Bits 3:0 give the row, and bit 5 selects the attribute/control plane (1) or the character-code plane (0). The byte after a row address is again in address position.
- R3: In a write transfer, a byte in address position with bit 7 = 0 is a column address, and bits 4:0 give the column. With bit 6 = 0, the next byte is data and is written to the latched row and column, and the byte after that is in address position again. A column address alone reuses the last row.
- R4: For character-plane writes, `wr_page` equals bit 5 of the last column address. For attribute-plane writes, `wr_page` is 0.
- R5: A column address with bit 6 = 1 starts streaming. Every later byte is data, whatever its value, until START or STOP. After each write the column advances by one, and from 31 it wraps to 0 while the row advances by one, with row 15 wrapping to 0.
- R6: A column address received before any row address since the last START is acknowledged but discarded. The parser stays in address position and no write follows.
- R7: A data byte aimed at row 15, column 24 or column 31 (either plane) is acknowledged but produces no write strobe, and streaming still advances past it.
- R8: The reset-flag register (row 15, column 23, attribute plane) is written by an ordinary write. When 0x7B is accepted its value appears on `tx_byte`. Reset clears it to 0x00, and bytes received during a read transfer are not acknowledged.
- R9: `start_evt` or `stop_evt` takes priority over an `rx_valid` byte in the same cycle, and that byte is discarded. START makes the next byte the slave address and forgets the row seen, and STOP returns the parser to idle.
- R10: After reset, `ack`, `wr_en` and `tx_byte` are 0, and bytes are ignored until a START.
- R11: `ack` and a write strobe appear in the cycle after the `rx_valid` cycle of the byte that caused them, and they last one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_evt | input | 1 | START or repeated START seen (one-cycle pulse) |
| stop_evt | input | 1 | STOP seen (one-cycle pulse) |
| rx_valid | input | 1 | A received byte is on `rx_byte` |
| rx_byte | input | 8 | Received byte |
| ack | output | 1 | Acknowledge for the byte of the previous cycle |
| tx_byte | output | 8 | Byte to return in a read transfer |
| wr_en | output | 1 | Write strobe to register memory |
| wr_row | output | 4 | Target row |
| wr_col | output | 5 | Target column |
| wr_attr | output | 1 | 1 = attribute/control plane, 0 = character plane |
| wr_page | output | 1 | Font page bit (bit 8 of the character code) |
| wr_data | output | 8 | Data to write |

## Verification
A bus event and a received byte can land in the same cycle, so the bench drives `stop_evt` or `start_evt` together with `rx_valid` in the middle of a transfer. It judges the outcome by the absence of `ack` and `wr_en` in the next cycle, and by how the following byte is treated. After the STOP, that byte is ignored. After the START, it is accepted as a slave address. A stream step and a reserved-register hit also coincide: at row 15, column 31 the write must vanish while the cursor still wraps, and the next write is checked to land at row 0, column 0.

// File: rtl/osd_cmd_pkg.sv
package osd_cmd_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    PS_IDLE,
    PS_SLAVE,
    PS_ADDR,
    PS_DATA,
    PS_STREAM,
    PS_READ
  } parse_st_e;
endpackage

// File: rtl/osd_byte_classify.sv
module osd_byte_classify
  import osd_cmd_pkg::*;
#(
  parameter int ROW_W = 4,
  parameter int COL_W = 5
) (
  input  logic [BYTE_W-1:0] byte_i,
  output logic              is_row_o,
  output logic [ROW_W-1:0]  row_o,
  output logic              attr_o,
  output logic [COL_W-1:0]  col_o,
  output logic              page_o,
  output logic              stream_o
);
  // bit 7 tags the address kind; row and column fields sit in the low bits
  always_comb begin
    is_row_o = byte_i[7];
    row_o    = byte_i[ROW_W-1:0];
    attr_o   = byte_i[5];
    col_o    = byte_i[COL_W-1:0];
    page_o   = byte_i[5];
    stream_o = byte_i[6];
  end
endmodule

// File: rtl/osd_cursor.sv
module osd_cursor #(
  parameter int ROW_W = 4,
  parameter int COL_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_row,
  input  logic [ROW_W-1:0] row_in,
  input  logic             attr_in,
  input  logic             ld_col,
  input  logic [COL_W-1:0] col_in,
  input  logic             page_in,
  input  logic             step,
  output logic [ROW_W-1:0] row_q,
  output logic [COL_W-1:0] col_q,
  output logic             attr_q,
  output logic             page_q
);
  localparam logic [COL_W-1:0] COL_LAST = {COL_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q  <= '0;
      col_q  <= '0;
      attr_q <= 1'b0;
      page_q <= 1'b0;
    end else begin
      if (ld_row) begin
        row_q  <= row_in;
        attr_q <= attr_in;
      end
      if (ld_col) begin
        col_q  <= col_in;
        page_q <= page_in;
      end else if (step) begin
        col_q <= col_q + 1'b1;
        if (col_q == COL_LAST) row_q <= row_q + 1'b1;
      end
    end
  end

  // stream step moves one column on (R5)
  assert_step_col_R5: assert property (@(posedge clk) disable iff (rst)
    (step && !ld_col && !ld_row) |=> (col_q == COL_W'($past(col_q) + 1'b1)));
  // wrap from the last column carries into the row (R5)
  assert_step_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (step && !ld_col && !ld_row && col_q == COL_LAST) |=> (col_q == '0 && row_q == ROW_W'($past(row_q) + 1'b1)));
endmodule

// File: rtl/osd_flag_reg.sv
module osd_flag_reg
  import osd_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (wr) q <= din;
  end

  assert_flag_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(q));
endmodule

// File: rtl/osd_cmd_parser.sv
module osd_cmd_parser
  import osd_cmd_pkg::*;
#(
  parameter int          ROW_W    = 4,
  parameter int          COL_W    = 5,
  parameter logic [7:0]  SLV_WR   = 8'h7A,
  parameter logic [7:0]  SLV_RD   = 8'h7B,
  parameter int          CTRL_ROW = 15,
  parameter int          FLAG_COL = 23,
  parameter int          RSVD_A   = 24,
  parameter int          RSVD_B   = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  output logic              ack,
  output logic [7:0]        tx_byte,
  output logic              wr_en,
  output logic [ROW_W-1:0]  wr_row,
  output logic [COL_W-1:0]  wr_col,
  output logic              wr_attr,
  output logic              wr_page,
  output logic [7:0]        wr_data
);
  localparam logic [ROW_W-1:0] CROW  = ROW_W'(CTRL_ROW);
  localparam logic [COL_W-1:0] FCOL  = COL_W'(FLAG_COL);
  localparam logic [COL_W-1:0] RCOLA = COL_W'(RSVD_A);
  localparam logic [COL_W-1:0] RCOLB = COL_W'(RSVD_B);

  parse_st_e st_q, st_d;
  logic row_seen_q;

  logic             b_is_row, b_attr, b_page, b_stream;
  logic [ROW_W-1:0] b_row;
  logic [COL_W-1:0] b_col;

  logic             ld_row, ld_col, step, do_wr, ack_d, rd_hit;
  logic [ROW_W-1:0] cur_row;
  logic [COL_W-1:0] cur_col;
  logic             cur_attr, cur_page;
  logic             rsvd_hit, wr_ok, flag_wr;
  logic [7:0]       flag_q;

  osd_byte_classify #(.ROW_W(ROW_W), .COL_W(COL_W)) u_cls (
    .byte_i   (rx_byte),
    .is_row_o (b_is_row),
    .row_o    (b_row),
    .attr_o   (b_attr),
    .col_o    (b_col),
    .page_o   (b_page),
    .stream_o (b_stream)
  );

  osd_cursor #(.ROW_W(ROW_W), .COL_W(COL_W)) u_cur (
    .clk     (clk),
    .rst     (rst),
    .ld_row  (ld_row),
    .row_in  (b_row),
    .attr_in (b_attr),
    .ld_col  (ld_col),
    .col_in  (b_col),
    .page_in (b_page),
    .step    (step),
    .row_q   (cur_row),
    .col_q   (cur_col),
    .attr_q  (cur_attr),
    .page_q  (cur_page)
  );

  osd_flag_reg u_flag (
    .clk (clk),
    .rst (rst),
    .wr  (flag_wr),
    .din (rx_byte),
    .q   (flag_q)
  );

  // byte classification and next-state decision
  always_comb begin
    st_d   = st_q;
    ld_row = 1'b0;
    ld_col = 1'b0;
    step   = 1'b0;
    do_wr  = 1'b0;
    ack_d  = 1'b0;
    rd_hit = 1'b0;
    if (start_evt) begin
      st_d = PS_SLAVE;
    end else if (stop_evt) begin
      st_d = PS_IDLE;
    end else if (rx_valid) begin
      unique case (st_q)
        PS_SLAVE: begin
          if (rx_byte == SLV_WR) begin
            ack_d = 1'b1;
            st_d  = PS_ADDR;
          end else if (rx_byte == SLV_RD) begin
            ack_d  = 1'b1;
            rd_hit = 1'b1;
            st_d   = PS_READ;
          end else begin
            st_d = PS_IDLE;
          end
        end
        PS_ADDR: begin
          ack_d = 1'b1;
          if (b_is_row) begin
            ld_row = 1'b1;
          end else if (row_seen_q) begin
            ld_col = 1'b1;
            st_d   = b_stream ? PS_STREAM : PS_DATA;
          end
        end
        PS_DATA: begin
          ack_d = 1'b1;
          do_wr = 1'b1;
          st_d  = PS_ADDR;
        end
        PS_STREAM: begin
          ack_d = 1'b1;
          do_wr = 1'b1;
          step  = 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign rsvd_hit = (cur_row == CROW) && ((cur_col == RCOLA) || (cur_col == RCOLB));
  assign wr_ok    = do_wr && !rsvd_hit;
  assign flag_wr  = wr_ok && cur_attr && (cur_row == CROW) && (cur_col == FCOL);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= PS_IDLE;
      row_seen_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (start_evt)   row_seen_q <= 1'b0;
      else if (ld_row) row_seen_q <= 1'b1;
    end
  end

  // registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      ack     <= 1'b0;
      tx_byte <= '0;
      wr_en   <= 1'b0;
      wr_row  <= '0;
      wr_col  <= '0;
      wr_attr <= 1'b0;
      wr_page <= 1'b0;
      wr_data <= '0;
    end else begin
      ack   <= ack_d;
      wr_en <= wr_ok;
      if (rd_hit) tx_byte <= flag_q;
      if (wr_ok) begin
        wr_row  <= cur_row;
        wr_col  <= cur_col;
        wr_attr <= cur_attr;
        wr_page <= cur_attr ? 1'b0 : cur_page;
        wr_data <= rx_byte;
      end
    end
  end

  assert_wr_after_rx_R11: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(rx_valid));
  assert_ack_after_rx_R11: assert property (@(posedge clk) disable iff (rst)
    ack |-> $past(rx_valid));
  assert_no_reserved_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_row == CROW) |-> (wr_col != RCOLA && wr_col != RCOLB));
  assert_attr_page_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_attr) |-> !wr_page);
  assert_evt_drops_R9: assert property (@(posedge clk) disable iff (rst)
    (start_evt || stop_evt) |=> (!wr_en && !ack));
  assert_no_col_first_R6: assert property (@(posedge clk) disable iff (rst)
    ld_col |-> row_seen_q);
endmodule

// File: tb/osd_cmd_parser_tb.sv
module osd_cmd_parser_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_evt = 1'b0, stop_evt = 1'b0, rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       ack, wr_en, wr_attr, wr_page;
  logic [7:0] tx_byte, wr_data;
  logic [3:0] wr_row;
  logic [4:0] wr_col;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  osd_cmd_parser dut_i (
    .clk(clk), .rst(rst), .start_evt(start_evt), .stop_evt(stop_evt),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .ack(ack), .tx_byte(tx_byte),
    .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col), .wr_attr(wr_attr),
    .wr_page(wr_page), .wr_data(wr_data)
  );

  // {req[27:24], start/stop/valid[23:21], byte[20:13], ack[12], wr[11], row[10:7], col[6:2], attr[1], page[0]}
  localparam int NV = 19;
  localparam logic [27:0] VEC [NV] = '{
    {4'd9,  3'b100, 8'h00, 1'b0, 1'b0, 4'd0, 5'd0,  1'b0, 1'b0}, // R9 START
    {4'd1,  3'b001, 8'h7A, 1'b1, 1'b0, 4'd0, 5'd0,  1'b0, 1'b0}, // R1 write address
    {4'd2,  3'b001, 8'h83, 1'b1, 1'b0, 4'd0, 5'd0,  1'b0, 1'b0}, // R2 row 3 char plane
    {4'd4,  3'b001, 8'h25, 1'b1, 1'b0, 4'd0, 5'd0,  1'b0, 1'b0}, // R4 col 5 page 1
    {4'd4,  3'b001, 8'h41, 1'b1, 1'b1, 4'd3, 5'd5,  1'b0, 1'b1}, // R4 data with page 1
    {4'd3,  3'b001, 8'h07, 1'b1, 1'b0, 4'd0, 5'd0,  1'b0, 1'b0}, // R3 column alone
    {4'd3,  3'b001, 8'h55, 1'b1, 1'b1, 4'd3, 5'd7,  1'b0, 1'b0}, // R3 same row
    {4'd2,  3'b001, 8'hA4, 1'b1, 1'b0, 4'd0, 5'd0,  1'b0, 1'b0}, // R2 row 4 attr plane
    {4'd3,  3'b001, 8'h1E, 1'b1, 1'b0, 4'd0, 5'd0,  1'b0, 1'b0}, // R3 col 30
    {4'd2,  3'b001, 8'h12, 1'b1, 1'b1, 4'd4, 5'd30, 1'b1, 1'b0}, // R2 attr write
    {4'd5,  3'b001, 8'h5F, 1'b1, 1'b0, 4'd0, 5'd0,  1'b0, 1'b0}, // R5 stream col 31
    {4'd5,  3'b001, 8'h01, 1'b1, 1'b1, 4'd4, 5'd31, 1'b1, 1'b0}, // R5
    {4'd5,  3'b001, 8'h02, 1'b1, 1'b1, 4'd5, 5'd0,  1'b1, 1'b0}, // R5 wrap to next row
    {4'd5,  3'b001, 8'h83, 1'b1, 1'b1, 4'd5, 5'd1,  1'b1, 1'b0}, // R5 row-like byte is data
    {4'd9,  3'b010, 8'h00, 1'b0, 1'b0, 4'd0, 5'd0,  1'b0, 1'b0}, // R9 STOP
    {4'd9,  3'b001, 8'h99, 1'b0, 1'b0, 4'd0, 5'd0,  1'b0, 1'b0}, // R9 idle byte ignored
    {4'd9,  3'b100, 8'h00, 1'b0, 1'b0, 4'd0, 5'd0,  1'b0, 1'b0}, // R9 START
    {4'd1,  3'b001, 8'h70, 1'b0, 1'b0, 4'd0, 5'd0,  1'b0, 1'b0}, // R1 foreign address
    {4'd1,  3'b001, 8'h83, 1'b0, 1'b0, 4'd0, 5'd0,  1'b0, 1'b0}  // R1 ignored after it
  };

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drive at a falling edge, outputs of that byte are sampled at the next falling edge
  task automatic step(input logic s, input logic p, input logic v, input logic [7:0] b);
    start_evt = s; stop_evt = p; rx_valid = v; rx_byte = b;
    @(negedge clk);
    start_evt = 1'b0; stop_evt = 1'b0; rx_valid = 1'b0;
  endtask

  task automatic wbyte(input logic [7:0] b);
    step(1'b0, 1'b0, 1'b1, b);
  endtask

  task automatic expect_wr(input string req, input logic [3:0] r, input logic [4:0] c,
                           input logic a, input logic [7:0] d);
    check(req, "wr_en", wr_en, 1);
    check(req, "wr_row", wr_row, r);
    check(req, "wr_col", wr_col, c);
    check(req, "wr_attr", wr_attr, a);
    check(req, "wr_data", wr_data, d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    check("R10", "ack", ack, 0);
    check("R10", "wr_en", wr_en, 0);
    check("R10", "tx_byte", tx_byte, 0);
    wbyte(8'h7A);
    check("R10", "byte before START ack", ack, 0);

    for (int i = 0; i < NV; i++) begin
      string rq;
      rq = $sformatf("R%0d", VEC[i][27:24]);
      step(VEC[i][23], VEC[i][22], VEC[i][21], VEC[i][20:13]);
      check(rq, $sformatf("vec%0d ack", i), ack, VEC[i][12]);
      check(rq, $sformatf("vec%0d wr_en", i), wr_en, VEC[i][11]);
      if (VEC[i][11]) begin
        check(rq, $sformatf("vec%0d row", i), wr_row, VEC[i][10:7]);
        check(rq, $sformatf("vec%0d col", i), wr_col, VEC[i][6:2]);
        check(rq, $sformatf("vec%0d attr", i), wr_attr, VEC[i][1]);
        check(rq, $sformatf("vec%0d page", i), wr_page, VEC[i][0]);
        check(rq, $sformatf("vec%0d data", i), wr_data, VEC[i][20:13]);
      end
    end

    // R8 read after reset returns 0, bytes in read not acked
    step(1'b1, 1'b0, 1'b0, 8'h00);
    wbyte(8'h7B);
    check("R8", "read ack", ack, 1);
    check("R8", "tx after reset", tx_byte, 8'h00);
    wbyte(8'h3C);
    check("R8", "byte in read ack", ack, 0);

    // R8 write flag register then read it
    step(1'b1, 1'b0, 1'b0, 8'h00);
    wbyte(8'h7A); wbyte(8'hAF); wbyte(8'h17);
    wbyte(8'hFF);
    expect_wr("R8", 4'd15, 5'd23, 1'b1, 8'hFF);
    // R7 reserved columns
    wbyte(8'h18); wbyte(8'h33);
    check("R7", "col24 ack", ack, 1);
    check("R7", "col24 wr_en", wr_en, 0);
    wbyte(8'h1F); wbyte(8'h34);
    check("R7", "col31 wr_en", wr_en, 0);
    wbyte(8'h16); wbyte(8'h44);
    expect_wr("R7", 4'd15, 5'd22, 1'b1, 8'h44);
    step(1'b0, 1'b1, 1'b0, 8'h00);
    step(1'b1, 1'b0, 1'b0, 8'h00);
    wbyte(8'h7B);
    check("R8", "tx after write", tx_byte, 8'hFF);

    // R5 with R7: stream across the reserved last column wraps to row 0
    step(1'b1, 1'b0, 1'b0, 8'h00);
    wbyte(8'h7A); wbyte(8'h8F); wbyte(8'h5E);
    wbyte(8'hA1);
    expect_wr("R5", 4'd15, 5'd30, 1'b0, 8'hA1);
    wbyte(8'hA2);
    check("R7", "stream col31 wr_en", wr_en, 0);
    check("R7", "stream col31 ack", ack, 1);
    wbyte(8'hA3);
    expect_wr("R5", 4'd0, 5'd0, 1'b0, 8'hA3);

    // R6 column before any row
    step(1'b1, 1'b0, 1'b0, 8'h00);
    wbyte(8'h7A); wbyte(8'h05);
    check("R6", "col ack", ack, 1);
    wbyte(8'h12);
    check("R6", "no write", wr_en, 0);

    // R9 STOP and byte in the same cycle
    wbyte(8'h83); wbyte(8'h01);
    step(1'b0, 1'b1, 1'b1, 8'h55);
    check("R9", "stop+byte wr_en", wr_en, 0);
    check("R9", "stop+byte ack", ack, 0);
    wbyte(8'h55);
    check("R9", "after stop ack", ack, 0);

    // R9 START and byte in the same cycle
    step(1'b1, 1'b0, 1'b0, 8'h00);
    wbyte(8'h7A); wbyte(8'h83); wbyte(8'h01);
    step(1'b1, 1'b0, 1'b1, 8'h66);
    check("R9", "start+byte wr_en", wr_en, 0);
    wbyte(8'h7A);
    check("R9", "slave after start ack", ack, 1);

    // R8 reset clears the flag register
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    step(1'b1, 1'b0, 1'b0, 8'h00);
    wbyte(8'h7B);
    check("R8", "tx after second reset", tx_byte, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule